// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block is the digital controller of a motherboard dual-rail supply. It watches two active-low sleep-control lines from the system, a flag that says the standby 5 V supply is above its power-on level, and a flag that says the 12 V main rail is good. From these it decides whether the board is active, in suspend-to-RAM, or in soft-off. It then drives four commands to the analog side: release of the pull-down that holds the main-supply pass gates off, enable of the PMOS that feeds the 5 V dual rail from standby, standby of the internal 3.3 V regulator, and a one-cycle request that starts the regulator's soft-start ramp.

The sleep lines are synchronized and deglitched before they are decoded. A move from soft-off straight to suspend is refused. The one input code that no valid system state uses leaves the controller where it is. Entry into suspend from active waits a fixed delay. Entry into soft-off takes effect as soon as the filtered code shows it. A wake waits for the 12 V flag and then for three soft-start periods. Only then are the pass gates released, the standby PMOS turned off and the regulator parked, all in one cycle. After standby power first comes up the controller waits one soft-start period and then requests the regulator soft-start.

All delays are counted in clock cycles derived from the clock frequency and the delay lengths given as parameters. A parameter selects whether the 5 V dual rail stays fed in soft-off.

Top module: `sleep_rail_seq`

## Requirements
- R1: The filtered line code {offLineN, ramLineN} decodes as follows: 11 requests active, 10 requests suspend-to-RAM, 00 requests soft-off. In active, passRelease=1, ldoStandby=1 and pmosOn=0.
- R2: The code 01 (ramLineN high, offLineN low) leaves the current state and all outputs unchanged.
- R3: From soft-off, the suspend code 10 is ignored: the block stays in soft-off and pmosOn keeps its soft-off value.
- R4: From active, the suspend code changes the outputs only after SUSP_US microseconds of clock cycles. The soft-off code changes them as soon as the filtered code shows it.
- R5: Active is entered only after the synchronized rail12Ok has been high for three soft-start periods without a break. A drop of rail12Ok during this wait restarts the count.
- R6: passRelease and ldoStandby always rise and fall in the same cycle, and pmosOn is 0 whenever passRelease is 1.
- R7: After sbyPorOk rises, ldoSoftStart pulses high for exactly one cycle, one soft-start period later. It never pulses while passRelease is 1.
- R8: In suspend pmosOn is 1. In soft-off pmosOn equals the KEEP_5V_OFF parameter. While waiting to wake, pmosOn keeps the value of the sleep state it came from.
- R9: A change on a sleep line that lasts fewer than DEGLITCH cycles after synchronization has no effect.
- R10: While sbyPorOk is low, all four outputs are 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| sbyPorOk | input | 1 | Standby 5 V above power-on level. Low acts as asynchronous reset |
| rail12Ok | input | 1 | 12 V main rail good (asynchronous) |
| ramLineN | input | 1 | Suspend-to-RAM sleep line, low means sleep requested (asynchronous) |
| offLineN | input | 1 | Soft-off sleep line, low means sleep requested (asynchronous) |
| passRelease | output | 1 | Release pull-down on main-supply pass gates |
| pmosOn | output | 1 | Turn on the standby-to-5 V dual PMOS |
| ldoStandby | output | 1 | Put the internal 3.3 V regulator in standby |
| ldoSoftStart | output | 1 | One-cycle request to start the regulator soft-start |

## Verification
The assertions assume that sbyPorOk is driven low at start and only then released. They also assume that rail12Ok holds its level across the few cycles of the synchronizer before a release, because the wake check looks at the raw flag two and three cycles back. The stimulus changes the sleep lines and the 12 V flag only on falling clock edges. It keeps every intended level for far longer than the deglitch window. Input pairs that change together switch on the same edge, so no unintended intermediate code reaches the decoder.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  // Sleep-state controller states
  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_OFF   = 3'd1,
    ST_RAM   = 3'd2,
    ST_WAKE  = 3'd3,
    ST_ACT   = 3'd4,
    ST_SUSPW = 3'd5
  } seqState_t;

  // Filtered line code {offLineN, ramLineN}
  typedef enum logic [1:0] {
    REQ_OFF = 2'b00,
    REQ_BAD = 2'b01,
    REQ_RAM = 2'b10,
    REQ_ACT = 2'b11
  } req_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic run;
  } tmrCmd_t;

  // Timer milestones from datapath to control
  typedef struct packed {
    logic bootDone;
    logic suspDone;
    logic wakeDone;
  } tmrFlag_t;

endpackage

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int unsigned DEGLITCH = 16,
  parameter int unsigned SS_CYC   = 410000,
  parameter int unsigned SUSP_CYC = 3000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ramLineN,
  input  logic     offLineN,
  input  logic     rail12Raw,
  input  tmrCmd_t  cmd,
  output req_t     req,
  output logic     rail12,
  output tmrFlag_t flag
);

  localparam int unsigned DW       = $clog2(DEGLITCH + 1);
  localparam int unsigned WAKE_CYC = 3 * SS_CYC;
  localparam int unsigned TMR_MAX  = (WAKE_CYC > SUSP_CYC) ? WAKE_CYC : SUSP_CYC;
  localparam int unsigned TW       = $clog2(TMR_MAX + 1);

  logic [1:0] rawIn;
  logic [1:0] filt;
  assign rawIn = {offLineN, ramLineN};

  // Synchronizer and deglitch filter per sleep line
  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [1:0]    syncQ;
    logic          filtQ;
    logic [DW-1:0] stableCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ     <= '0;
        filtQ     <= 1'b0;
        stableCnt <= '0;
      end else begin
        syncQ <= {syncQ[0], rawIn[i]};
        if (syncQ[1] != filtQ) begin
          if (stableCnt == DW'(DEGLITCH - 1)) begin
            filtQ     <= syncQ[1];
            stableCnt <= '0;
          end else begin
            stableCnt <= stableCnt + DW'(1);
          end
        end else begin
          stableCnt <= '0;
        end
      end
    end
    assign filt[i] = filtQ;
  end

  assign req = req_t'(filt);

  // 12 V good synchronizer
  logic [1:0] r12Sync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) r12Sync <= '0;
    else       r12Sync <= {r12Sync[0], rail12Raw};
  end
  assign rail12 = r12Sync[1];

  // Shared saturating interval timer
  logic [TW-1:0] tmr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (cmd.clr) begin
      tmr <= '0;
    end else if (cmd.run && (tmr < TW'(TMR_MAX - 1))) begin
      tmr <= tmr + TW'(1);
    end
  end

  assign flag.bootDone = (tmr == TW'(SS_CYC - 1));
  assign flag.suspDone = (tmr == TW'(SUSP_CYC - 1));
  assign flag.wakeDone = (tmr == TW'(WAKE_CYC - 1));

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
#(
  parameter bit KEEP_5V_OFF = 1'b0
) (
  input  logic     clk,
  input  logic     rstN,
  input  req_t     req,
  input  logic     rail12,
  input  tmrFlag_t flag,
  output tmrCmd_t  cmd,
  output logic     passRelease,
  output logic     pmosOn,
  output logic     ldoStandby,
  output logic     ldoSoftStart
);

  seqState_t state, nxt;
  logic      fromRam;
  logic      ssPulse;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_BOOT: begin
        if (flag.bootDone) begin
          if (req == REQ_ACT)      nxt = ST_WAKE;
          else if (req == REQ_RAM) nxt = ST_RAM;
          else                     nxt = ST_OFF;
        end
      end
      ST_OFF: begin
        // suspend code from soft-off is refused
        if (req == REQ_ACT) nxt = ST_WAKE;
      end
      ST_RAM: begin
        if (req == REQ_ACT)      nxt = ST_WAKE;
        else if (req == REQ_OFF) nxt = ST_OFF;
      end
      ST_WAKE: begin
        unique case (req)
          REQ_ACT: if (flag.wakeDone && rail12) nxt = ST_ACT;
          REQ_OFF: nxt = ST_OFF;
          REQ_RAM: if (fromRam) nxt = ST_RAM;
          default: nxt = state;
        endcase
      end
      ST_ACT: begin
        if (req == REQ_OFF)      nxt = ST_OFF;
        else if (req == REQ_RAM) nxt = ST_SUSPW;
      end
      ST_SUSPW: begin
        if (req == REQ_OFF)                       nxt = ST_OFF;
        else if (req == REQ_ACT)                  nxt = ST_ACT;
        else if (req == REQ_RAM && flag.suspDone) nxt = ST_RAM;
      end
      default: nxt = ST_BOOT;
    endcase
  end

  assign cmd.clr = (nxt != state) || (state == ST_WAKE && !rail12);
  assign cmd.run = (state != ST_OFF) && (state != ST_RAM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_BOOT;
      fromRam <= 1'b0;
      ssPulse <= 1'b0;
    end else begin
      state   <= nxt;
      ssPulse <= (state == ST_BOOT) && (nxt != ST_BOOT);
      if (nxt == ST_WAKE && state != ST_WAKE) fromRam <= (state == ST_RAM);
    end
  end

  logic awake;
  assign awake        = (state == ST_ACT) || (state == ST_SUSPW);
  assign passRelease  = awake;
  assign ldoStandby   = awake;
  assign ldoSoftStart = ssPulse;
  assign pmosOn       = (state == ST_RAM)
                      || (state == ST_OFF  && KEEP_5V_OFF)
                      || (state == ST_WAKE && (fromRam || KEEP_5V_OFF));

endmodule

// File: rtl/sleep_rail_seq.sv
module sleep_rail_seq
  import sleep_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned SUSP_US     = 60,
  parameter int unsigned SS_US       = 8200,
  parameter int unsigned DEGLITCH    = 16,
  parameter bit          KEEP_5V_OFF = 1'b0
) (
  input  logic clk,
  input  logic sbyPorOk,
  input  logic rail12Ok,
  input  logic ramLineN,
  input  logic offLineN,
  output logic passRelease,
  output logic pmosOn,
  output logic ldoStandby,
  output logic ldoSoftStart
);

  localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
  localparam int unsigned SUSP_RAW   = CYC_PER_MS * SUSP_US / 1000;
  localparam int unsigned SS_RAW     = CYC_PER_MS * SS_US / 1000;
  localparam int unsigned SUSP_CYC   = (SUSP_RAW < 2) ? 2 : SUSP_RAW;
  localparam int unsigned SS_CYC     = (SS_RAW < 2) ? 2 : SS_RAW;

  req_t     req;
  logic     rail12;
  tmrCmd_t  cmd;
  tmrFlag_t flag;

  sleep_seq_dp #(
    .DEGLITCH (DEGLITCH),
    .SS_CYC   (SS_CYC),
    .SUSP_CYC (SUSP_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (sbyPorOk),
    .ramLineN  (ramLineN),
    .offLineN  (offLineN),
    .rail12Raw (rail12Ok),
    .cmd       (cmd),
    .req       (req),
    .rail12    (rail12),
    .flag      (flag)
  );

  sleep_seq_ctrl #(
    .KEEP_5V_OFF (KEEP_5V_OFF)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (sbyPorOk),
    .req          (req),
    .rail12       (rail12),
    .flag         (flag),
    .cmd          (cmd),
    .passRelease  (passRelease),
    .pmosOn       (pmosOn),
    .ldoStandby   (ldoStandby),
    .ldoSoftStart (ldoSoftStart)
  );

endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
  input logic clk,
  input logic sbyPorOk,
  input logic rail12Ok,
  input logic passRelease,
  input logic pmosOn,
  input logic ldoStandby,
  input logic ldoSoftStart
);

  // R6: release and regulator standby move together
  p_lockstep_r6: assert property (@(posedge clk) disable iff (!sbyPorOk)
    passRelease == ldoStandby);

  // R6: standby PMOS is off whenever pass gates are released
  p_pmos_off_r6: assert property (@(posedge clk) disable iff (!sbyPorOk)
    passRelease |-> !pmosOn);

  // R5: release only after 12 V good was seen through the synchronizer
  p_needs_12v_r5: assert property (@(posedge clk) disable iff (!sbyPorOk)
    $rose(passRelease) |-> ($past(rail12Ok, 2) && $past(rail12Ok, 3)));

  // R7: soft-start request is a single-cycle pulse
  p_ss_pulse_r7: assert property (@(posedge clk) disable iff (!sbyPorOk)
    ldoSoftStart |=> !ldoSoftStart);

  // R7: no soft-start request while awake
  p_ss_quiet_r7: assert property (@(posedge clk) disable iff (!sbyPorOk)
    ldoSoftStart |-> !passRelease);

  // R10: all outputs safe while standby power is not good
  p_safe_reset_r10: assert property (@(posedge clk)
    !sbyPorOk |-> (!passRelease && !pmosOn && !ldoStandby && !ldoSoftStart));

endmodule

bind sleep_rail_seq sleep_seq_chk u_chk (.*);

// File: tb/tb_sleep_rail_seq.sv
module tb_sleep_rail_seq;

  logic clk = 1'b0;
  logic sbyPorOk, rail12Ok, ramLineN, offLineN;
  logic passRelease, pmosOn, ldoStandby, ldoSoftStart;
  logic altRelease, altPmos, altStandby, altSoftStart;

  int total = 0;
  int bad   = 0;
  int ssCount = 0;
  int splitSeen = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // 1 MHz nominal: suspend delay 40 cycles, soft-start period 50 cycles
  sleep_rail_seq #(.CLK_HZ(1_000_000), .SUSP_US(40), .SS_US(50),
                   .DEGLITCH(4), .KEEP_5V_OFF(1'b0)) dut (
    .clk(clk), .sbyPorOk(sbyPorOk), .rail12Ok(rail12Ok),
    .ramLineN(ramLineN), .offLineN(offLineN),
    .passRelease(passRelease), .pmosOn(pmosOn),
    .ldoStandby(ldoStandby), .ldoSoftStart(ldoSoftStart));

  sleep_rail_seq #(.CLK_HZ(1_000_000), .SUSP_US(40), .SS_US(50),
                   .DEGLITCH(4), .KEEP_5V_OFF(1'b1)) dutAlt (
    .clk(clk), .sbyPorOk(sbyPorOk), .rail12Ok(rail12Ok),
    .ramLineN(ramLineN), .offLineN(offLineN),
    .passRelease(altRelease), .pmosOn(altPmos),
    .ldoStandby(altStandby), .ldoSoftStart(altSoftStart));

  // Monitors sampled away from the active edge
  always @(negedge clk) begin
    if (sbyPorOk === 1'b1) begin
      if (ldoSoftStart) ssCount++;
      if (passRelease !== ldoStandby) splitSeen++;
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b {rel,pmos,stby,altPmos}", tag, act, exp);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {passRelease, pmosOn, ldoStandby, altPmos};
  endfunction

  typedef struct packed {
    logic        ram;
    logic        off;
    logic        r12;
    logic [15:0] waitCyc;
    logic [3:0]  exp;   // {rel, pmos, stby, altPmos}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'd20,  4'b0001, 4'd1},  // R1 soft-off after boot
    '{1'b0, 1'b1, 1'b0, 16'd40,  4'b0001, 4'd3},  // R3 suspend from soft-off refused
    '{1'b1, 1'b1, 1'b0, 16'd300, 4'b0001, 4'd5},  // R5 no 12 V, no wake
    '{1'b1, 1'b1, 1'b1, 16'd100, 4'b0001, 4'd5},  // R5 under three periods
    '{1'b1, 1'b1, 1'b1, 16'd100, 4'b1010, 4'd1},  // R1 active reached
    '{1'b1, 1'b0, 1'b1, 16'd20,  4'b1010, 4'd2},  // R2 forbidden code holds active
    '{1'b0, 1'b1, 1'b1, 16'd20,  4'b1010, 4'd4},  // R4 suspend still delayed
    '{1'b0, 1'b1, 1'b1, 16'd60,  4'b0101, 4'd8},  // R8 suspend, PMOS on
    '{1'b1, 1'b0, 1'b1, 16'd40,  4'b0101, 4'd2},  // R2 forbidden code holds suspend
    '{1'b1, 1'b1, 1'b1, 16'd250, 4'b1010, 4'd1},  // R1 wake from suspend
    '{1'b0, 1'b0, 1'b1, 16'd12,  4'b0001, 4'd4},  // R4 soft-off is immediate
    '{1'b0, 1'b1, 1'b1, 16'd60,  4'b0001, 4'd3}   // R3 refused again
  };

  initial begin
    sbyPorOk = 1'b0; rail12Ok = 1'b0; ramLineN = 1'b0; offLineN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {passRelease, pmosOn, ldoStandby, ldoSoftStart}, 4'b0000);
    sbyPorOk = 1'b1;
    repeat (30) @(negedge clk);
    chkInt("R7 no early soft-start", ssCount, 0);
    repeat (30) @(negedge clk);
    chkInt("R7 one soft-start pulse", ssCount, 1);

    for (int i = 0; i < NV; i++) begin
      ramLineN = VEC[i].ram; offLineN = VEC[i].off; rail12Ok = VEC[i].r12;
      repeat (int'(VEC[i].waitCyc)) @(negedge clk);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), outs(), VEC[i].exp);
    end

    // R9: short glitch to soft-off code while active
    ramLineN = 1'b1; offLineN = 1'b1;
    repeat (250) @(negedge clk);
    chk("R5 active before glitch", outs(), 4'b1010);
    ramLineN = 1'b0; offLineN = 1'b0;
    repeat (2) @(negedge clk);
    ramLineN = 1'b1; offLineN = 1'b1;
    repeat (30) @(negedge clk);
    chk("R9 glitch ignored", outs(), 4'b1010);

    // R5: 12 V break restarts the wait
    ramLineN = 1'b0; offLineN = 1'b0; rail12Ok = 1'b0;
    repeat (20) @(negedge clk);
    ramLineN = 1'b1; offLineN = 1'b1; rail12Ok = 1'b1;
    repeat (100) @(negedge clk);
    rail12Ok = 1'b0;
    repeat (5) @(negedge clk);
    rail12Ok = 1'b1;
    repeat (100) @(negedge clk);
    chk("R5 wait restarted", outs(), 4'b0001);
    repeat (100) @(negedge clk);
    chk("R5 active after full wait", outs(), 4'b1010);
    chkInt("R6 no split cycle", splitSeen, 0);

    // R10: asynchronous return to safe state
    @(negedge clk);
    #5 sbyPorOk = 1'b0;
    #1 chk("R10 async safe", {passRelease, pmosOn, ldoStandby, ldoSoftStart}, 4'b0000);
    @(negedge clk);
    sbyPorOk = 1'b1;
    repeat (60) @(negedge clk);
    chkInt("R7 soft-start after re-power", ssCount, 2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule